// File: doc/BRIEF.md
# Speculative Commit Core with Tagged Register File

This block lets instructions finish their arithmetic out of program order while their results reach the architectural registers strictly in program order. Each issued instruction claims two resources. It takes a slot in a circular eight-entry result buffer. It also takes one of four waiting stations. Every architectural register carries a valid flag and the tag of the buffer slot that will next write it, so a later reader knows where its value will come from.

At issue, each source operand is taken from one of three places. If the register is valid, the register supplies it. If not, and the result bus is broadcasting that register's tag in the same cycle, the bus supplies it. Otherwise it comes from the buffer slot named by the register's tag, and the station waits on that tag if the slot has no result yet. A station whose operands are both present is handed to a two-stage execution unit. The unit's finished result goes out on a single result bus only in a cycle where the bus grant input is high. The broadcast completes the buffer slot and wakes every station waiting on that tag.

The oldest slot retires once it holds a result. Its value is written to its destination register. The register becomes valid again only if no younger instruction has since claimed it.

Top module: `rob_core`

## Requirements
- R1: After reset, every register reads as valid with value zero, `issue_ready` is high and `commit_valid` is low.
- R2: `issue_ready` is low whenever all four stations are occupied or eight instructions are in flight. An `issue_valid` presented while `issue_ready` is low is dropped: it never commits and writes no register.
- R3: Operation codes on `issue_op` are 0 = add, 1 = subtract (src1 minus src2), 2 = bitwise xor and 3 = load immediate (result is `issue_imm`, sources ignored). All arithmetic wraps at 16 bits. Each result equals the in-order value, whatever the dependences between in-flight instructions.
- R4: An instruction issued with `issue_has_dst` low commits with `commit_wr` low and changes no register.
- R5: Instructions commit one at a time in exactly the order they were accepted. `commit_reg` and `commit_data` give the destination and value.
- R6: No instruction completes in a cycle where `cdb_gnt` is low. While the grant stays low, nothing new commits.
- R7: In an idle machine with `cdb_gnt` high, an instruction with ready operands that is accepted at clock edge E shows `commit_valid` after edge E+3 and not after edge E+2. Its register reads updated after edge E+4.
- R8: When a register has a younger pending writer, retiring an older write stores the older value but leaves the register non-valid. The register turns valid when its youngest writer retires.
- R9: While the unit's output stage waits for a grant, the unit holds at most two instructions. Ready stations stay parked, so with the grant held low exactly six instructions are accepted before `issue_ready` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Instruction offered for issue |
| issue_op | input | 2 | Operation code (see R3) |
| issue_src1 | input | 3 | First source register |
| issue_src2 | input | 3 | Second source register |
| issue_has_dst | input | 1 | Instruction writes a register |
| issue_dst | input | 3 | Destination register |
| issue_imm | input | 16 | Immediate for load immediate |
| issue_ready | output | 1 | A station and a buffer slot are free |
| cdb_gnt | input | 1 | Result bus granted to the execution unit |
| commit_valid | output | 1 | Oldest instruction retires this cycle |
| commit_wr | output | 1 | Retiring instruction writes a register |
| commit_reg | output | 3 | Destination of the retiring instruction |
| commit_data | output | 16 | Value of the retiring instruction |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register value |
| rd_valid | output | 1 | Register holds its latest value |

## Verification
A directed chain of back-to-back dependent instructions forces each of the three operand sources in turn: register, same-cycle bus and buffer slot. A wrong pick appears as a wrong committed value. Two writes to one register, with a single-cycle grant pulse between them, separate the stale-producer rule from a plain valid-on-retire rule. Holding the grant low separates the hold of the unit's stages from the station limit on issue. Streams of random dependent instructions under a random grant are compared commit by commit and register by register against an in-order model. They mix no-destination instructions with all four operations.

// File: rtl/rob_core.sv
module rob_core #(
  parameter int ROB_N = 8,
  parameter int RS_N  = 4,
  parameter int NREG  = 8,
  parameter int W     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue_valid,
  input  logic [1:0]              issue_op,
  input  logic [$clog2(NREG)-1:0] issue_src1,
  input  logic [$clog2(NREG)-1:0] issue_src2,
  input  logic                    issue_has_dst,
  input  logic [$clog2(NREG)-1:0] issue_dst,
  input  logic [W-1:0]            issue_imm,
  output logic                    issue_ready,
  input  logic                    cdb_gnt,
  output logic                    commit_valid,
  output logic                    commit_wr,
  output logic [$clog2(NREG)-1:0] commit_reg,
  output logic [W-1:0]            commit_data,
  input  logic [$clog2(NREG)-1:0] rd_addr,
  output logic [W-1:0]            rd_data,
  output logic                    rd_valid
);
  localparam int TW = $clog2(ROB_N);
  localparam int RW = $clog2(NREG);
  localparam int SW = $clog2(RS_N);
  localparam logic [TW:0] FULL_CNT = (TW+1)'(ROB_N);
  localparam logic [1:0] OP_ADD = 2'd0, OP_SUB = 2'd1, OP_XOR = 2'd2, OP_LDI = 2'd3;

  logic [NREG-1:0][W-1:0]  rf_data;
  logic [NREG-1:0]         rf_valid;
  logic [NREG-1:0][TW-1:0] rf_tag;

  logic [ROB_N-1:0]         rob_done, rob_wr;
  logic [ROB_N-1:0][RW-1:0] rob_dst;
  logic [ROB_N-1:0][W-1:0]  rob_data;
  logic [TW-1:0]            head, tail;
  logic [TW:0]              cnt;

  logic [RS_N-1:0]          rs_full, rs_v1, rs_v2;
  logic [RS_N-1:0][1:0]     rs_op;
  logic [RS_N-1:0][TW-1:0]  rs_tag, rs_q1, rs_q2;
  logic [RS_N-1:0][W-1:0]   rs_d1, rs_d2, rs_imm;

  logic          s1_v, s2_v;
  logic [TW-1:0] s1_tag, s2_tag;
  logic [W-1:0]  s1_res, s2_res;

  logic          cdb_fire;
  logic [TW-1:0] cdb_tag;
  logic [W-1:0]  cdb_data;
  logic          issue_fire, retire_fire, disp_fire;
  logic          s1_free, s2_free;
  logic          free_any, disp_any;
  logic [SW-1:0] free_idx, disp_idx;
  logic [W-1:0]  alu;
  logic [W+TW:0] op1, op2;

  assign s2_free     = !s2_v || cdb_gnt;
  assign s1_free     = !s1_v || s2_free;
  assign cdb_fire    = s2_v && cdb_gnt;
  assign cdb_tag     = s2_tag;
  assign cdb_data    = s2_res;
  assign issue_ready = free_any && (cnt != FULL_CNT);
  assign issue_fire  = issue_valid && issue_ready;
  assign disp_fire   = disp_any && s1_free;
  assign retire_fire = (cnt != '0) && rob_done[head];

  assign commit_valid = retire_fire;
  assign commit_wr    = rob_wr[head];
  assign commit_reg   = rob_dst[head];
  assign commit_data  = rob_data[head];
  assign rd_data      = rf_data[rd_addr];
  assign rd_valid     = rf_valid[rd_addr];

  function automatic logic [W+TW:0] fetch(input logic [RW-1:0] r);
    logic [TW-1:0] t;
    t = rf_tag[r];
    if (issue_op == OP_LDI || rf_valid[r]) return {1'b1, t, rf_data[r]};
    else if (cdb_fire && cdb_tag == t)     return {1'b1, t, cdb_data};
    else                                   return {rob_done[t], t, rob_data[t]};
  endfunction

  assign op1 = fetch(issue_src1);
  assign op2 = fetch(issue_src2);

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    disp_any = 1'b0;
    disp_idx = '0;
    for (int i = RS_N - 1; i >= 0; i--) begin
      if (!rs_full[i]) begin
        free_any = 1'b1;
        free_idx = SW'(i);
      end
      if (rs_full[i] && rs_v1[i] && rs_v2[i]) begin
        disp_any = 1'b1;
        disp_idx = SW'(i);
      end
    end
  end

  always_comb begin
    case (rs_op[disp_idx])
      OP_ADD:  alu = rs_d1[disp_idx] + rs_d2[disp_idx];
      OP_SUB:  alu = rs_d1[disp_idx] - rs_d2[disp_idx];
      OP_XOR:  alu = rs_d1[disp_idx] ^ rs_d2[disp_idx];
      default: alu = rs_imm[disp_idx];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_data  <= '0;
      rf_valid <= '1;
      rf_tag   <= '0;
      rob_done <= '0;
      rob_wr   <= '0;
      rob_dst  <= '0;
      rob_data <= '0;
    end else begin
      if (retire_fire && rob_wr[head]) begin
        rf_data[rob_dst[head]] <= rob_data[head];
        if (rf_tag[rob_dst[head]] == head) rf_valid[rob_dst[head]] <= 1'b1;
      end
      if (issue_fire) begin
        rob_done[tail] <= 1'b0;
        rob_wr[tail]   <= issue_has_dst;
        rob_dst[tail]  <= issue_dst;
        if (issue_has_dst) begin
          rf_tag[issue_dst]   <= tail;
          rf_valid[issue_dst] <= 1'b0;
        end
      end
      if (cdb_fire) begin
        rob_done[cdb_tag] <= 1'b1;
        rob_data[cdb_tag] <= cdb_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_full <= '0;
      rs_v1   <= '0;
      rs_v2   <= '0;
      rs_op   <= '0;
      rs_tag  <= '0;
      rs_q1   <= '0;
      rs_q2   <= '0;
      rs_d1   <= '0;
      rs_d2   <= '0;
      rs_imm  <= '0;
    end else begin
      for (int i = 0; i < RS_N; i++) begin
        if (issue_fire && free_idx == SW'(i)) begin
          rs_full[i] <= 1'b1;
          rs_tag[i]  <= tail;
          rs_op[i]   <= issue_op;
          rs_imm[i]  <= issue_imm;
          {rs_v1[i], rs_q1[i], rs_d1[i]} <= op1;
          {rs_v2[i], rs_q2[i], rs_d2[i]} <= op2;
        end else if (rs_full[i]) begin
          if (!rs_v1[i] && cdb_fire && rs_q1[i] == cdb_tag) begin
            rs_v1[i] <= 1'b1;
            rs_d1[i] <= cdb_data;
          end
          if (!rs_v2[i] && cdb_fire && rs_q2[i] == cdb_tag) begin
            rs_v2[i] <= 1'b1;
            rs_d2[i] <= cdb_data;
          end
          if (disp_fire && disp_idx == SW'(i)) rs_full[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_tag <= '0;
      s1_res <= '0;
      s2_v   <= 1'b0;
      s2_tag <= '0;
      s2_res <= '0;
      head   <= '0;
      tail   <= '0;
      cnt    <= '0;
    end else begin
      if (s2_free) begin
        s2_v   <= s1_v;
        s2_tag <= s1_tag;
        s2_res <= s1_res;
      end
      if (s1_free) begin
        s1_v   <= disp_fire;
        s1_tag <= rs_tag[disp_idx];
        s1_res <= alu;
      end
      tail <= tail + TW'(issue_fire);
      head <= head + TW'(retire_fire);
      cnt  <= cnt + (TW+1)'(issue_fire) - (TW+1)'(retire_fire);
    end
  end
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int ROB_N = 8,
  parameter int NREG  = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          issue_valid,
  input logic                          issue_ready,
  input logic                          issue_has_dst,
  input logic [$clog2(NREG)-1:0]       issue_dst,
  input logic                          cdb_gnt,
  input logic                          commit_valid,
  input logic                          commit_wr,
  input logic [$clog2(NREG)-1:0]       commit_reg,
  input logic [$clog2(ROB_N):0]        cnt,
  input logic [$clog2(ROB_N)-1:0]      head,
  input logic                          s1_v,
  input logic [$clog2(ROB_N)-1:0]      s1_tag,
  input logic                          s2_v,
  input logic [$clog2(ROB_N)-1:0]      s2_tag,
  input logic [NREG-1:0]               rf_valid,
  input logic [NREG-1:0][$clog2(ROB_N)-1:0] rf_tag
);
  localparam int TW = $clog2(ROB_N);
  localparam logic [TW:0] FULL_CNT = (TW+1)'(ROB_N);

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  p_full_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL_CNT) |-> !issue_ready);

  p_hold_nogrant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && !cdb_gnt) |=> (s2_v && $stable(s2_tag)));

  p_unit_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s2_v && !cdb_gnt) |=> (s1_v && $stable(s1_tag)));

  p_stale_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_wr && rf_tag[commit_reg] != head)
      |=> !rf_valid[$past(commit_reg)]);

  p_latest_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_wr && rf_tag[commit_reg] == head &&
     !(issue_valid && issue_ready && issue_has_dst && issue_dst == commit_reg))
      |=> rf_valid[$past(commit_reg)]);
endmodule

bind rob_core rob_core_chk #(.ROB_N(ROB_N), .NREG(NREG)) chk_i (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
  .issue_has_dst(issue_has_dst), .issue_dst(issue_dst), .cdb_gnt(cdb_gnt),
  .commit_valid(commit_valid), .commit_wr(commit_wr), .commit_reg(commit_reg),
  .cnt(cnt), .head(head), .s1_v(s1_v), .s1_tag(s1_tag), .s2_v(s2_v), .s2_tag(s2_tag),
  .rf_valid(rf_valid), .rf_tag(rf_tag)
);

// File: tb/rob_core_tb_top.sv
module rob_core_tb_top;
  localparam int NREG = 8;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         issue_valid = 1'b0;
  logic [1:0]   issue_op = '0;
  logic [2:0]   issue_src1 = '0, issue_src2 = '0, issue_dst = '0, rd_addr = '0;
  logic         issue_has_dst = 1'b0;
  logic [W-1:0] issue_imm = '0;
  logic         issue_ready, cdb_gnt, commit_valid, commit_wr, rd_valid;
  logic [2:0]   commit_reg;
  logic [W-1:0] commit_data, rd_data;

  logic gnt_force = 1'b0, rand_gnt = 1'b0, gnt_rnd = 1'b0;
  assign cdb_gnt = rand_gnt ? gnt_rnd : gnt_force;
  always @(negedge clk) gnt_rnd <= ($urandom_range(9) < 7);

  rob_core dut_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_src1(issue_src1), .issue_src2(issue_src2), .issue_has_dst(issue_has_dst),
    .issue_dst(issue_dst), .issue_imm(issue_imm), .issue_ready(issue_ready),
    .cdb_gnt(cdb_gnt), .commit_valid(commit_valid), .commit_wr(commit_wr),
    .commit_reg(commit_reg), .commit_data(commit_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  typedef struct packed { logic wr; logic [2:0] r; logic [W-1:0] d; } exp_t;
  exp_t exp_q[$];
  logic [W-1:0] ref_rf [NREG];
  int n_checks = 0, n_fail = 0, commits = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  always @(negedge clk) begin
    if (rst_n && commit_valid) begin
      commits++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected commit of reg", commit_reg, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(commit_wr == e.wr, "R4", "commit_wr", commit_wr, e.wr);
        if (e.wr) begin
          check(commit_reg == e.r, "R5", "commit_reg", commit_reg, e.r);
          check(commit_data == e.d, "R3", "commit_data", commit_data, e.d);
        end
      end
    end
  end

  task automatic drive(input logic [1:0] op, input logic [2:0] s1, input logic [2:0] s2,
                       input logic hd, input logic [2:0] d, input logic [W-1:0] imm);
    exp_t e;
    logic [W-1:0] v;
    issue_op = op; issue_src1 = s1; issue_src2 = s2;
    issue_has_dst = hd; issue_dst = d; issue_imm = imm;
    issue_valid = 1'b1;
    case (op)
      2'd0: v = ref_rf[s1] + ref_rf[s2];
      2'd1: v = ref_rf[s1] - ref_rf[s2];
      2'd2: v = ref_rf[s1] ^ ref_rf[s2];
      default: v = imm;
    endcase
    e.wr = hd; e.r = d; e.d = v;
    exp_q.push_back(e);
    if (hd) ref_rf[d] = v;
  endtask

  task automatic issue(input logic [1:0] op, input logic [2:0] s1, input logic [2:0] s2,
                       input logic hd, input logic [2:0] d, input logic [W-1:0] imm);
    while (!issue_ready) @(negedge clk);
    drive(op, s1, s2, hd, d, imm);
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, req, "pending commits after drain", exp_q.size(), 0);
  endtask

  task automatic cmp_regs(input string req);
    for (int r = 0; r < NREG; r++) begin
      rd_addr = 3'(r);
      #1;
      check(rd_data == ref_rf[r] && rd_valid, req, $sformatf("reg %0d value/valid", r),
            {rd_valid, rd_data}, {1'b1, ref_rf[r]});
    end
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "R5", "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    int acc;
    int c0;
    for (int r = 0; r < NREG; r++) ref_rf[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(issue_ready == 1'b1, "R1", "issue_ready", issue_ready, 1);
    check(commit_valid == 1'b0, "R1", "commit_valid", commit_valid, 0);
    cmp_regs("R1");

    // R7: latency in an idle machine
    gnt_force = 1'b1;
    drive(2'd3, 3'd0, 3'd0, 1'b1, 3'd1, 16'h1234);
    rd_addr = 3'd1;
    @(negedge clk);
    issue_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(commit_valid == 1'b0, "R7", "commit after E+2", commit_valid, 0);
    @(negedge clk);
    check(commit_valid == 1'b1, "R7", "commit after E+3", commit_valid, 1);
    @(negedge clk);
    check(rd_data == 16'h1234 && rd_valid, "R7", "reg 1 after E+4", rd_data, 16'h1234);

    // R3: back-to-back dependent chain
    issue(2'd3, 3'd0, 3'd0, 1'b1, 3'd2, 16'h0005);
    issue(2'd0, 3'd2, 3'd2, 1'b1, 3'd3, 16'h0);
    issue(2'd1, 3'd3, 3'd2, 1'b1, 3'd4, 16'h0);
    issue(2'd2, 3'd4, 3'd3, 1'b1, 3'd5, 16'h0);
    issue(2'd1, 3'd2, 3'd1, 1'b1, 3'd2, 16'h0);
    issue(2'd0, 3'd5, 3'd2, 1'b0, 3'd6, 16'h0);
    issue(2'd0, 3'd2, 3'd5, 1'b1, 3'd0, 16'h0);
    drain("R3");
    cmp_regs("R3");

    // R6: no completion without grant
    gnt_force = 1'b0;
    c0 = commits;
    issue(2'd3, 3'd0, 3'd0, 1'b1, 3'd2, 16'h0055);
    repeat (10) @(negedge clk);
    check(commits == c0, "R6", "commits with grant low", commits - c0, 0);
    gnt_force = 1'b1;
    drain("R6");
    cmp_regs("R6");

    // R8: older retire with a younger pending writer
    gnt_force = 1'b0;
    issue(2'd3, 3'd0, 3'd0, 1'b1, 3'd6, 16'h0005);
    issue(2'd3, 3'd0, 3'd0, 1'b1, 3'd6, 16'h0007);
    repeat (4) @(negedge clk);
    gnt_force = 1'b1;
    @(negedge clk);
    gnt_force = 1'b0;
    @(negedge clk);
    rd_addr = 3'd6;
    #1;
    check(rd_data == 16'h0005, "R8", "reg 6 after older retire", rd_data, 16'h0005);
    check(rd_valid == 1'b0, "R8", "reg 6 valid with younger writer", rd_valid, 0);
    gnt_force = 1'b1;
    drain("R8");
    cmp_regs("R8");

    // R2 / R9: station limit with grant held low, dropped issue attempts
    gnt_force = 1'b0;
    acc = 0;
    for (int k = 0; k < 10; k++) begin
      if (issue_ready) begin
        drive(2'd3, 3'd0, 3'd0, 1'b1, 3'(k % 6), 16'(16'h0100 + k));
        acc++;
      end else begin
        issue_valid = 1'b0;
      end
      @(negedge clk);
    end
    issue_valid = 1'b0;
    check(acc == 6, "R9", "accepted with grant low", acc, 6);
    check(issue_ready == 1'b0, "R2", "issue_ready with stations full", issue_ready, 0);
    issue_op = 2'd3; issue_has_dst = 1'b1; issue_dst = 3'd7; issue_imm = 16'hDEAD;
    issue_valid = 1'b1;
    repeat (3) @(negedge clk);
    issue_valid = 1'b0;
    gnt_force = 1'b1;
    drain("R2");
    cmp_regs("R2");

    // R3 / R4 / R5: random dependent streams under a random grant
    for (int s = 0; s < 3; s++) begin
      rand_gnt = 1'b1;
      for (int n = 0; n < 80; n++) begin
        issue(2'($urandom_range(3)), 3'($urandom_range(7)), 3'($urandom_range(7)),
              ($urandom_range(7) != 0), 3'($urandom_range(7)), 16'($urandom));
      end
      rand_gnt = 1'b0;
      gnt_force = 1'b1;
      drain("R5");
      cmp_regs("R4");
    end

    report();
    $finish;
  end
endmodule